// File: doc/BRIEF.md
# Odd-Multiple Table Constant Multiplier

This block multiplies a 5-bit unsigned sample by a coefficient that is fixed for the life of a run. It does not hold a full 32-entry product table. Each product is written as 16A plus or minus a coded magnitude, and the magnitude is rebuilt from a nine-word table. Eight of the words are the odd multiples A, 3A, … 15A and one word is 2A. The top input bit picks add or subtract. The lower four bits give the magnitude: the bits themselves when the top bit is 1, and their two's complement (16 minus the value) when it is 0. An address generator removes the trailing zeros from the magnitude. What remains selects an odd multiple, and the number of zeros removed sets a left shift of 0 to 3 places.

The coefficient is captured from `coef_i` on every clock edge at which the synchronous active-low reset is held. The table is filled at the same time, and the value is then frozen until the next reset. Samples enter with a valid strobe. The product leaves exactly two clock edges later with its own strobe. One register stage follows the table read and one follows the add/subtract.

Top module: `oddmul_lut_mult`

## Requirements
- R1: For every sample X in 0..31 accepted with `x_valid_i` high, `p_o` equals A*X (A being the captured coefficient) on the output, with no overflow, two rising edges later.
- R2: `p_valid_o` is high exactly in the cycles that follow the second rising edge after an edge at which `x_valid_i` was high. Otherwise it is low.
- R3: While `rst_ni` is low, after the first rising edge `p_valid_o` reads 0 and `p_o` reads 0.
- R4: The coefficient is taken from `coef_i` only while `rst_ni` is low. A change of `coef_i` while `rst_ni` is high has no effect on any later product.
- R5: Input 5'b10000 yields exactly 16A: the coded word is forced to zero and is not read from the table.
- R6: Input 5'b00000 yields exactly 0, formed as 16A minus the 2A entry shifted left three places.
- R7: A coefficient of 0 yields 0 for every input. The largest coefficient (all ones) yields 31*A at input 31 within the (W+5)-bit product.
- R8: When no valid sample reaches the output stage, `p_o` holds its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Synchronous active-low reset; coefficient and table load while low |
| coef_i | input | W | Coefficient A, captured during reset |
| x_valid_i | input | 1 | Sample strobe |
| x_i | input | 5 | Unsigned sample X |
| p_valid_o | output | 1 | Product strobe, two cycles after `x_valid_i` |
| p_o | output | W+5 | Product A*X |

## Verification
Every one of the 32 sample values is driven against coefficients 0, 1, 90, 173 and the all-ones maximum. This covers every table word, every shift count and both signs, and the maximum shows whether the top product bit is lost. Back-to-back streaming shows whether the two pipeline stages mix samples. A run with idle gaps in a scrambled order checks the strobe and the hold of the product, and it would expose a latency counted from the wrong edge. In every run `coef_i` is changed after reset is released, so any path that still reads the live pin shows up as wrong products.

// File: rtl/oddmul_pkg.sv
// Shared constants and types for the odd-multiple table multiplier.
// Assumes a fixed 5-bit sample; the coefficient width is a parameter of the users.
package oddmul_pkg;
    localparam int SAMPLE_W = 5;                 // sample width (fixed)
    localparam int MAG_W    = SAMPLE_W - 1;      // coded magnitude width
    localparam int ADDR_W   = MAG_W;             // table address width
    localparam int N_WORDS  = (1 << (MAG_W - 1)) + 1; // odd multiples plus the 2A word
    localparam int SH_W     = 2;                 // shift control width (0..3)
    localparam int TWO_A_ADDR = N_WORDS - 1;     // address of the 2A word

    // Decoded control for one sample
    typedef struct packed {
        logic [ADDR_W-1:0] addr;   // odd-multiple word address
        logic [SH_W-1:0]   shamt;  // left-shift count
        logic              zero;   // force coded word to zero
        logic              add;    // 1: 16A + word, 0: 16A - word
    } map_t;
endpackage

// File: rtl/oddmul_addr_gen.sv
// Maps a 5-bit sample to table address, shift count, zero force and sign.
// Purely combinational. Magnitude is the low bits when the top bit is set,
// otherwise 16 minus them; a zero magnitude with top bit clear means 16.
module oddmul_addr_gen
    import oddmul_pkg::*;
(
    input  logic [SAMPLE_W-1:0] x_i,
    output map_t                map_o
);
    logic [MAG_W-1:0] low;
    logic [MAG_W-1:0] mag;
    logic [MAG_W-1:0] odd;
    logic [SH_W-1:0]  sh;

    assign low = x_i[MAG_W-1:0];

    // Form the coded magnitude from the sign bit and low bits
    always_comb begin
        if (x_i[SAMPLE_W-1]) mag = low;
        else                 mag = MAG_W'(0) - low;
    end

    // Count trailing zeros of the magnitude (0..3 for nonzero values)
    always_comb begin
        if (mag[0])      sh = 2'd0;
        else if (mag[1]) sh = 2'd1;
        else if (mag[2]) sh = 2'd2;
        else             sh = 2'd3;
        odd = mag >> sh;
    end

    // Assemble address, shift, zero force and sign
    always_comb begin
        map_o.add = x_i[SAMPLE_W-1];
        if (low == '0) begin
            map_o.addr  = ADDR_W'(TWO_A_ADDR);
            map_o.shamt = 2'd3;
            map_o.zero  = x_i[SAMPLE_W-1];
        end else begin
            map_o.addr  = ADDR_W'(odd >> 1);
            map_o.shamt = sh;
            map_o.zero  = 1'b0;
        end
    end
endmodule

// File: rtl/oddmul_decoder.sv
// Turns a table address into one-hot word-select lines, one per table word.
// Assumes the address never exceeds the last word index.
module oddmul_decoder
    import oddmul_pkg::*;
(
    input  logic [ADDR_W-1:0]  addr_i,
    output logic [N_WORDS-1:0] sel_o
);
    for (genvar i = 0; i < N_WORDS; i++) begin : g_sel
        // One compare per word-select line
        assign sel_o[i] = (addr_i == ADDR_W'(i));
    end
endmodule

// File: rtl/oddmul_table.sv
// Nine-word product table: (2i+1)*A at i < 8 and 2A at the last word.
// Loaded from the coefficient while reset is low, frozen afterwards.
// The read is an AND-OR over one-hot selects, gated to zero by zero_i.
module oddmul_table
    import oddmul_pkg::*;
#(
    parameter int W = 8,
    localparam int WORD_W = W + MAG_W
)(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [W-1:0]       coef_i,
    input  logic [N_WORDS-1:0] sel_i,
    input  logic               zero_i,
    output logic [WORD_W-1:0]  word_o
);
    logic [WORD_W-1:0] words [N_WORDS];

    for (genvar i = 0; i < N_WORDS; i++) begin : g_word
        // Load this word from the coefficient while reset is held
        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                if (i == TWO_A_ADDR) words[i] <= WORD_W'(coef_i) << 1;
                else                 words[i] <= WORD_W'(coef_i) * WORD_W'(2 * i + 1);
            end
        end
    end

    // AND-OR read of the selected word with the zero force
    always_comb begin
        word_o = '0;
        for (int i = 0; i < N_WORDS; i++) begin
            if (sel_i[i]) word_o = word_o | words[i];
        end
        if (zero_i) word_o = '0;
    end
endmodule

// File: rtl/oddmul_shifter.sv
// Logarithmic left shifter: one stage per control bit, stage k shifts by 2^k.
// Assumes OUT_W leaves room for the largest shift of the input.
module oddmul_shifter #(
    parameter int IN_W  = 12,
    parameter int OUT_W = 13,
    parameter int SH_W  = 2
)(
    input  logic [IN_W-1:0]  d_i,
    input  logic [SH_W-1:0]  sh_i,
    output logic [OUT_W-1:0] q_o
);
    logic [OUT_W-1:0] stage [SH_W+1];

    assign stage[0] = OUT_W'(d_i);
    for (genvar k = 0; k < SH_W; k++) begin : g_stage
        // Conditional shift by 2^k
        assign stage[k+1] = sh_i[k] ? (stage[k] << (1 << k)) : stage[k];
    end
    assign q_o = stage[SH_W];
endmodule

// File: rtl/oddmul_lut_mult.sv
// Top: constant multiplier built from a nine-word odd-multiple table.
// Stage 1 registers the table read, shift count and sign; stage 2 shifts,
// adds to or subtracts from 16A, and registers the product. Latency 2.
// Assumes coef_i is valid while rst_ni is low; it is ignored afterwards.
module oddmul_lut_mult
    import oddmul_pkg::*;
#(
    parameter int W = 8,
    localparam int WORD_W = W + MAG_W,
    localparam int PROD_W = W + SAMPLE_W
)(
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [W-1:0]        coef_i,
    input  logic                x_valid_i,
    input  logic [SAMPLE_W-1:0] x_i,
    output logic                p_valid_o,
    output logic [PROD_W-1:0]   p_o
);
    map_t               map;
    logic [N_WORDS-1:0] word_sel;
    logic [WORD_W-1:0]  rd_word;
    logic [W-1:0]       coef_q;

    logic               s1_v;
    logic [WORD_W-1:0]  s1_word;
    logic [SH_W-1:0]    s1_sh;
    logic               s1_add;

    logic [PROD_W-1:0]  shifted;
    logic [PROD_W-1:0]  base;

    oddmul_addr_gen u_addr (.x_i(x_i), .map_o(map));

    oddmul_decoder u_dec (.addr_i(map.addr), .sel_o(word_sel));

    oddmul_table #(.W(W)) u_tab (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .coef_i(coef_i),
        .sel_i (word_sel),
        .zero_i(map.zero),
        .word_o(rd_word)
    );

    // Capture the coefficient for the 16A base while reset is held
    always_ff @(posedge clk_i) begin
        if (!rst_ni) coef_q <= coef_i;
    end

    // Stage 1: register table read and control
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s1_v    <= 1'b0;
            s1_word <= '0;
            s1_sh   <= '0;
            s1_add  <= 1'b0;
        end else begin
            s1_v <= x_valid_i;
            if (x_valid_i) begin
                s1_word <= rd_word;
                s1_sh   <= map.shamt;
                s1_add  <= map.add;
            end
        end
    end

    oddmul_shifter #(.IN_W(WORD_W), .OUT_W(PROD_W), .SH_W(SH_W)) u_shf (
        .d_i (s1_word),
        .sh_i(s1_sh),
        .q_o (shifted)
    );

    assign base = PROD_W'(coef_q) << MAG_W;

    // Stage 2: add/subtract around 16A and register the product
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            p_valid_o <= 1'b0;
            p_o       <= '0;
        end else begin
            p_valid_o <= s1_v;
            if (s1_v) p_o <= s1_add ? (base + shifted) : (base - shifted);
        end
    end
endmodule

// File: rtl/oddmul_lut_mult_chk.sv
// Checker for oddmul_lut_mult: keeps its own two-deep copy of the sample
// stream and relates the product port to it. Attached by bind below.
module oddmul_lut_mult_chk
    import oddmul_pkg::*;
#(
    parameter int W = 8,
    localparam int PROD_W = W + SAMPLE_W
)(
    input logic                clk_i,
    input logic                rst_ni,
    input logic                x_valid_i,
    input logic [SAMPLE_W-1:0] x_i,
    input logic                p_valid_o,
    input logic [PROD_W-1:0]   p_o,
    input logic [W-1:0]        coef_q,
    input logic [N_WORDS-1:0]  word_sel
);
    logic                v_d1, v_d2;
    logic [SAMPLE_W-1:0] x_d1, x_d2;
    logic [PROD_W-1:0]   expect_p;

    // Delay line of the sample stream
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            v_d1 <= 1'b0; v_d2 <= 1'b0; x_d1 <= '0; x_d2 <= '0;
        end else begin
            v_d1 <= x_valid_i; v_d2 <= v_d1; x_d1 <= x_i; x_d2 <= x_d1;
        end
    end

    assign expect_p = PROD_W'(coef_q) * PROD_W'(x_d2);

    p_product_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        v_d2 |-> p_o == expect_p);
    p_sel_onehot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot(word_sel));
    p_valid_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        p_valid_o == v_d2);
    p_coef_frozen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $stable(coef_q));
    p_mid_input_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (v_d2 && x_d2 == 5'b10000) |-> p_o == (PROD_W'(coef_q) << 4));
    p_zero_input_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (v_d2 && x_d2 == 5'b00000) |-> p_o == '0);
    p_zero_coef_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (coef_q == '0) |-> p_o == '0);
    p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !v_d2 |-> $stable(p_o));
endmodule

bind oddmul_lut_mult oddmul_lut_mult_chk #(.W(W)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .x_valid_i(x_valid_i),
    .x_i      (x_i),
    .p_valid_o(p_valid_o),
    .p_o      (p_o),
    .coef_q   (coef_q),
    .word_sel (word_sel)
);

// File: tb/oddmul_lut_mult_test.sv
`timescale 1ns/1ps
// Sweeps every sample value for several coefficients and checks A*X arithmetically.
module oddmul_lut_mult_test;
    localparam int W = 8;
    localparam int PW = W + 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  coef = '0;
    logic          xv = 1'b0;
    logic [4:0]    x = '0;
    logic          pv;
    logic [PW-1:0] p;

    int checks = 0;
    int fails  = 0;

    oddmul_lut_mult #(.W(W)) uut (
        .clk_i(clk), .rst_ni(rst_n), .coef_i(coef),
        .x_valid_i(xv), .x_i(x), .p_valid_o(pv), .p_o(p)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reset with coefficient a, then sweep all 32 samples with the given gap and stride
    task automatic run(input int a, input int gap, input int stride);
        int hv [200];
        int hx [200];
        int idx = 0;
        int last = 0;
        int n = 32 * (gap + 1) + 3;
        rst_n = 1'b0; coef = W'(a); xv = 1'b0; x = '0;
        repeat (3) @(negedge clk);
        check("R3 reset valid", longint'(pv), 0);
        check("R3 reset product", longint'(p), 0);
        rst_n = 1'b1;
        coef = ~W'(a);                       // R4: later coefficient changes ignored
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            if (c >= 2) begin
                if (hv[c-2] != 0) begin
                    last = a * hx[c-2];
                    check("R2 valid", longint'(pv), 1);
                    if (hx[c-2] == 16)      check("R5 mid input", longint'(p), last);
                    else if (hx[c-2] == 0)  check("R6 zero input", longint'(p), 0);
                    else if (a == 0)        check("R7 zero coef", longint'(p), 0);
                    else if (a == 255)      check("R7 max coef", longint'(p), last);
                    else                    check("R1/R4 product", longint'(p), last);
                end else begin
                    check("R2 idle valid", longint'(pv), 0);
                    check("R8 hold", longint'(p), last);
                end
            end
            if (c < 32 * (gap + 1) && (c % (gap + 1)) == 0) begin
                xv = 1'b1;
                x = 5'((idx * stride + 3) % 32);
                hv[c] = 1; hx[c] = (idx * stride + 3) % 32;
                idx++;
            end else begin
                xv = 1'b0;
                x = 5'(c * 7);               // junk on idle cycles
                hv[c] = 0; hx[c] = 0;
            end
        end
    endtask

    initial begin
        run(0,   0, 1);
        run(1,   0, 1);
        run(173, 0, 1);
        run(90,  0, 1);
        run(255, 0, 1);
        run(255, 1, 13);
        run(173, 2, 5);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule